// File: doc/BRIEF.md
# Optical Pickup Track Jump Sequencer

This block runs the timed kick-and-brake sequences that move an optical pickup across disc tracks. A host writes one jump command: its kind (single track, ten tracks, a long jump of any length, or a sled-only move), a direction and a track count. While the sequence runs, the block drives the tracking kick, the sled kick and the two servo-enable outputs. It counts crossings on the track-crossing comparator and on the mirror comparator. Each comparator input first goes through a two-stage synchronizer and a rising-edge detector.

All waiting is measured in ticks of one shared enable input, so a slow tick gives real millisecond delays and a fast tick gives short test runs. Four time fields set the delays: a blind time after the kick, a fixed brake time for single-track jumps, an overflow time (the crossing period that counts as "slow enough") and a settle time between the tracking servo and the sled servo coming back. The settle field is 4 bits with binary weights, one tick being the smallest step. Braking on the multi-track jumps stops once the track-crossing period grows longer than the overflow time. Long jumps count track crossings for the first sixteen and mirror edges after that.

States: `ST_IDLE` (servos as last left), `ST_NULL` (one busy cycle for a zero count), `ST_BLIND` (kick applied, crossings ignored), `ST_COUNT` (kick applied, crossings counted), `ST_BRAKE_T` (opposite track kick for a fixed time), `ST_BRAKE_OVF` (opposite track kick until the crossing period exceeds the overflow time), `ST_SETTLE` (tracking servo on, sled servo off). Transitions: IDLE→NULL on a command with count zero. IDLE→BLIND on any other command. NULL→IDLE always. BLIND→COUNT when the blind time expires. COUNT→BRAKE_T (single track), COUNT→BRAKE_OVF (ten-track or long jump) or COUNT→IDLE (sled move) on the last counted crossing. BRAKE_T→IDLE when the brake time expires. BRAKE_OVF→SETTLE (long jump) or BRAKE_OVF→IDLE (ten-track) when the overflow time passes with no crossing. SETTLE→IDLE when the settle time expires.

Top module: `trkjmp_seq`

## Requirements
- R1: After reset the block is idle: `busy` low, both servo enables high, all four kick outputs low.
- R2: `busy` rises on the cycle after a command is accepted in idle. A command presented while `busy` is high has no effect on the running sequence.
- R3: Kind 0 (single track): the track kick is applied in the commanded direction with both servos off. After the blind time and then one track crossing, the opposite track kick is applied. The sequence then ends with both servos on and `busy` low on the same cycle.
- R4: Crossings that arrive during the blind time are not counted.
- R5: The fixed brake of a single-track jump lasts exactly `t_brake` ticks (one tick minimum).
- R6: Kind 1 (ten track): track and sled are kicked together, and five track crossings after the blind time start the overflow brake. During that brake only the opposite track kick is applied, and it ends with both servos on.
- R7: The overflow brake continues while track crossings keep arriving less than `t_ovf` ticks apart, and ends once `t_ovf` ticks pass with no crossing.
- R8: Kind 2 (long jump of `cmd_count` tracks): the first 16 counted edges are track crossings, all later ones are mirror edges, and the sequence ends with the overflow brake.
- R9: After the long-jump brake, the tracking servo is on and the sled servo off for exactly `t_settle` ticks, then both are on.
- R10: Kind 3 (sled move of M tracks): only the sled is kicked, with both servos off. Track crossings are counted when M is below 16 and mirror edges otherwise. On the M-th edge the block returns to idle with both servos off.
- R11: A command with `cmd_count` zero holds `busy` high for one cycle and leaves the servo enables and kicks unchanged.
- R12: `cmd_rev` = 1 swaps forward and reverse on every kick and brake output.
- R13: Timers advance only on cycles where `tick` is high; with `tick` low a timed step never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable for all timers |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_kind | input | 2 | 0 single, 1 ten-track, 2 long jump, 3 sled move |
| cmd_rev | input | 1 | 1 = reverse direction |
| cmd_count | input | CW (16) | Track count; zero ends at once |
| t_blind | input | TW (4) | Blind time in ticks |
| t_brake | input | TW (4) | Single-track brake time in ticks |
| t_ovf | input | TW (4) | Overflow crossing period in ticks |
| t_settle | input | TW (4) | Sled delay after tracking servo on, in ticks |
| cout_in | input | 1 | Track-crossing comparator, asynchronous |
| mirr_in | input | 1 | Mirror comparator, asynchronous |
| busy | output | 1 | High while a sequence runs |
| trk_servo_on | output | 1 | Tracking servo enable |
| sled_servo_on | output | 1 | Sled servo enable |
| trk_kick_fwd | output | 1 | Forward track kick |
| trk_kick_rev | output | 1 | Reverse track kick |
| sled_kick_fwd | output | 1 | Forward sled kick |
| sled_kick_rev | output | 1 | Reverse sled kick |

## Verification
The assertions assume that each comparator level, high or low, lasts at least one clock, so that every crossing gives exactly one detected rising edge. They also assume that the four time fields do not change while `busy` is high, because the active step reads its field live. The stimulus holds each time field constant for the whole run. It drives each crossing as one clock high followed by at least one clock low, and it sends commands only as single-cycle strobes.

// File: rtl/trkjmp_pkg.sv
package trkjmp_pkg;

    typedef enum logic [1:0] {
        JT_ONE   = 2'd0,
        JT_TEN   = 2'd1,
        JT_MULTI = 2'd2,
        JT_MOVE  = 2'd3
    } jump_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NULL,
        ST_BLIND,
        ST_COUNT,
        ST_BRAKE_T,
        ST_BRAKE_OVF,
        ST_SETTLE
    } seq_state_t;

endpackage

// File: rtl/trkjmp_edge.sv
module trkjmp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/trkjmp_timer.sv
module trkjmp_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clr)                       cnt_q <= '0;
        else if (tick && (cnt_q != '1))     cnt_q <= cnt_q + 1'b1;
    end

    assign done = tick && (({1'b0, cnt_q} + 1'b1) >= {1'b0, len});

    // R13
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/trkjmp_seq.sv
module trkjmp_seq
    import trkjmp_pkg::*;
#(
    parameter int CW        = 16,
    parameter int TW        = 4,
    parameter int SYNC      = 2,
    parameter int TEN_CROSS = 5,
    parameter int MIRR_FROM = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic          cmd_rev,
    input  logic [CW-1:0] cmd_count,
    input  logic [TW-1:0] t_blind,
    input  logic [TW-1:0] t_brake,
    input  logic [TW-1:0] t_ovf,
    input  logic [TW-1:0] t_settle,
    input  logic          cout_in,
    input  logic          mirr_in,
    output logic          busy,
    output logic          trk_servo_on,
    output logic          sled_servo_on,
    output logic          trk_kick_fwd,
    output logic          trk_kick_rev,
    output logic          sled_kick_fwd,
    output logic          sled_kick_rev
);
    localparam logic [CW-1:0] TEN_TGT  = CW'(TEN_CROSS);
    localparam logic [CW-1:0] MIRR_TGT = CW'(MIRR_FROM);

    seq_state_t state_q, state_d;
    jump_kind_t kind_q;
    logic       rev_q;
    logic [CW-1:0] target_q, ecnt_q, ecnt_nx;
    logic       trk_en_q, sled_en_q;

    // edge detectors for both comparators
    logic [1:0] raw_in, rise_v;
    assign raw_in = {mirr_in, cout_in};

    for (genvar g = 0; g < 2; g++) begin : g_edge
        trkjmp_edge #(.STAGES(SYNC)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise_v[g])
        );
    end

    logic cout_rise, mirr_rise;
    assign cout_rise = rise_v[0];
    assign mirr_rise = rise_v[1];

    // step timer
    logic [TW-1:0] tlen;
    logic          tclr, tdone;

    always_comb begin
        unique case (state_q)
            ST_BLIND:     tlen = t_blind;
            ST_BRAKE_T:   tlen = t_brake;
            ST_BRAKE_OVF: tlen = t_ovf;
            ST_SETTLE:    tlen = t_settle;
            default:      tlen = '0;
        endcase
    end

    assign tclr = (state_d != state_q) || ((state_q == ST_BRAKE_OVF) && cout_rise);

    trkjmp_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tclr),
        .tick (tick),
        .len  (tlen),
        .done (tdone)
    );

    // crossing selection and counting
    logic accept, use_mirr, xing, last_xing;
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign use_mirr  = ((kind_q == JT_MULTI) && (ecnt_q >= MIRR_TGT)) ||
                       ((kind_q == JT_MOVE)  && (target_q >= MIRR_TGT));
    assign xing      = use_mirr ? mirr_rise : cout_rise;
    assign ecnt_nx   = ecnt_q + 1'b1;
    assign last_xing = xing && (ecnt_nx == target_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (cmd_count == '0) ? ST_NULL : ST_BLIND;
            ST_NULL:  state_d = ST_IDLE;
            ST_BLIND: if (tdone) state_d = ST_COUNT;
            ST_COUNT: if (last_xing) begin
                unique case (kind_q)
                    JT_ONE:          state_d = ST_BRAKE_T;
                    JT_TEN, JT_MULTI: state_d = ST_BRAKE_OVF;
                    JT_MOVE:         state_d = ST_IDLE;
                    default:         state_d = ST_IDLE;
                endcase
            end
            ST_BRAKE_T: if (tdone) state_d = ST_IDLE;
            ST_BRAKE_OVF: if (tdone && !cout_rise)
                state_d = (kind_q == JT_MULTI) ? ST_SETTLE : ST_IDLE;
            ST_SETTLE: if (tdone) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command and servo registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= JT_ONE;
            rev_q     <= 1'b0;
            target_q  <= '0;
            ecnt_q    <= '0;
            trk_en_q  <= 1'b1;
            sled_en_q <= 1'b1;
        end else begin
            if (accept) begin
                kind_q <= jump_kind_t'(cmd_kind);
                rev_q  <= cmd_rev;
                ecnt_q <= '0;
                unique case (jump_kind_t'(cmd_kind))
                    JT_ONE:  target_q <= CW'(1);
                    JT_TEN:  target_q <= TEN_TGT;
                    default: target_q <= cmd_count;
                endcase
            end else if ((state_q == ST_COUNT) && xing) begin
                ecnt_q <= ecnt_nx;
            end
            if ((state_q == ST_COUNT) && (state_d == ST_IDLE)) begin
                trk_en_q  <= 1'b0;
                sled_en_q <= 1'b0;
            end else if ((state_q inside {ST_BRAKE_T, ST_BRAKE_OVF, ST_SETTLE}) &&
                         (state_d == ST_IDLE)) begin
                trk_en_q  <= 1'b1;
                sled_en_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        trk_servo_on  = 1'b0;
        sled_servo_on = 1'b0;
        trk_kick_fwd  = 1'b0;
        trk_kick_rev  = 1'b0;
        sled_kick_fwd = 1'b0;
        sled_kick_rev = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_NULL: begin
                trk_servo_on  = trk_en_q;
                sled_servo_on = sled_en_q;
            end
            ST_BLIND, ST_COUNT: begin
                if (kind_q != JT_MOVE) begin
                    trk_kick_fwd = !rev_q;
                    trk_kick_rev = rev_q;
                end
                if (kind_q != JT_ONE) begin
                    sled_kick_fwd = !rev_q;
                    sled_kick_rev = rev_q;
                end
            end
            ST_BRAKE_T, ST_BRAKE_OVF: begin
                trk_kick_fwd = rev_q;
                trk_kick_rev = !rev_q;
            end
            ST_SETTLE: trk_servo_on = 1'b1;
            default: ;
        endcase
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R2
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (target_q == $past(target_q)));

    // R3
    kick_servo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_kick_fwd || trk_kick_rev || sled_kick_fwd || sled_kick_rev) |->
        (!trk_servo_on && !sled_servo_on));

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (ecnt_q < target_q));

    // R11
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_count == '0)) |=>
        (busy && $stable({trk_servo_on, sled_servo_on})) ##1 !busy);

    // R12
    kick_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({trk_kick_fwd, trk_kick_rev}) <= 1 &&
        $countones({sled_kick_fwd, sled_kick_rev}) <= 1);

endmodule

// File: tb/trkjmp_seq_bench.sv
module trkjmp_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'd0;
    logic cmd_rev = 1'b0;
    logic [15:0] cmd_count = 16'd0;
    logic [3:0] t_blind = 4'd8, t_brake = 4'd6, t_ovf = 4'd5, t_settle = 4'd7;
    logic cout_in = 1'b0, mirr_in = 1'b0;
    logic busy, trk_servo_on, sled_servo_on;
    logic trk_kick_fwd, trk_kick_rev, sled_kick_fwd, sled_kick_rev;

    always #4 clk = ~clk;

    trkjmp_seq u_trkjmp_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_rev(cmd_rev), .cmd_count(cmd_count),
        .t_blind(t_blind), .t_brake(t_brake), .t_ovf(t_ovf), .t_settle(t_settle),
        .cout_in(cout_in), .mirr_in(mirr_in), .busy(busy),
        .trk_servo_on(trk_servo_on), .sled_servo_on(sled_servo_on),
        .trk_kick_fwd(trk_kick_fwd), .trk_kick_rev(trk_kick_rev),
        .sled_kick_fwd(sled_kick_fwd), .sled_kick_rev(sled_kick_rev)
    );

    // {busy, trk_on, sled_on, trk_fwd, trk_rev, sled_fwd, sled_rev}
    logic [6:0] obs;
    assign obs = {busy, trk_servo_on, sled_servo_on, trk_kick_fwd, trk_kick_rev,
                  sled_kick_fwd, sled_kick_rev};

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] exp_q[$];
    string      tag_q[$];
    logic [6:0] prev;
    bit mon_on = 1'b0;
    bit ended = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic push(input logic [6:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor: every change of the output vector is compared with the queue
    always @(negedge clk) begin
        if (!mon_on) prev = obs;
        else if (obs !== prev) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected change", int'(obs), 0);
            else begin
                logic [6:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(obs === e, t, int'(obs), int'(e));
            end
            prev = obs;
        end
    end

    task automatic send(input logic [1:0] k, input logic r, input logic [15:0] n);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_kind = k; cmd_rev = r; cmd_count = n;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_c();
        @(posedge clk); #2 cout_in = 1'b1;
        @(posedge clk); #2 cout_in = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic pulse_m();
        @(posedge clk); #2 mirr_in = 1'b1;
        @(posedge clk); #2 mirr_in = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic idle_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_vec(input logic [6:0] v, input string req);
        int n = 0;
        @(negedge clk);
        while (obs !== v && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(obs === v, req, int'(obs), int'(v));
    endtask

    task automatic hold_len(input logic [6:0] v, output int n);
        n = 0;
        while (obs === v && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int len;
        idle_cyc(4);
        rst_n = 1'b1;
        idle_cyc(1);
        // R1 reset state
        chk(obs === 7'b0110000, "R1", int'(obs), 7'h30);
        mon_on = 1'b1;
        idle_cyc(1);

        // single track forward, with an ignored command and an early crossing
        push(7'b1001000, "R3 kick"); push(7'b1000100, "R3 brake"); push(7'b0110000, "R3 end");
        chk(!busy, "R2 idle before", int'(busy), 0);
        send(2'd0, 1'b0, 16'd1);
        chk(busy, "R2 busy after accept", int'(busy), 1);
        send(2'd3, 1'b1, 16'd5);           // R2 ignored while busy
        pulse_c();                         // R4 falls in blind time
        idle_cyc(12);
        chk(obs === 7'b1001000, "R4 blind crossing ignored", int'(obs), 7'h48);
        pulse_c();
        wait_vec(7'b1000100, "R3 brake start");
        hold_len(7'b1000100, len);
        chk(len == 6, "R5 brake length", len, 6);
        wait_vec(7'b0110000, "R3 servos restored");

        // ten track forward
        push(7'b1001010, "R6 kick"); push(7'b1000100, "R6 brake"); push(7'b0110000, "R6 end");
        send(2'd1, 1'b0, 16'd10);
        idle_cyc(12);
        repeat (4) pulse_c();
        idle_cyc(3);
        chk(obs === 7'b1001010, "R6 four crossings not enough", int'(obs), 7'h4a);
        pulse_c();
        wait_vec(7'b1000100, "R6 brake start");
        repeat (5) pulse_c();
        chk(obs === 7'b1000100, "R7 brake held by fast crossings", int'(obs), 7'h44);
        wait_vec(7'b0110000, "R7 brake ends");

        // long jump reverse, 18 tracks
        push(7'b1000101, "R12 kick"); push(7'b1001000, "R12 brake");
        push(7'b1100000, "R9 settle"); push(7'b0110000, "R9 end");
        send(2'd2, 1'b1, 16'd18);
        idle_cyc(12);
        repeat (16) pulse_c();
        repeat (3) pulse_c();
        idle_cyc(3);
        chk(obs === 7'b1000101, "R8 crossings past 16 ignored", int'(obs), 7'h45);
        pulse_m();
        idle_cyc(3);
        chk(obs === 7'b1000101, "R8 one mirror edge", int'(obs), 7'h45);
        pulse_m();
        wait_vec(7'b1001000, "R8 brake after mirror edges");
        wait_vec(7'b1100000, "R9 settle start");
        hold_len(7'b1100000, len);
        chk(len == 7, "R9 settle length", len, 7);
        chk(obs === 7'b0110000, "R9 both servos on", int'(obs), 7'h30);

        // sled move forward, 3 tracks: counts crossings
        push(7'b1000010, "R10 move"); push(7'b0000000, "R10 end");
        send(2'd3, 1'b0, 16'd3);
        idle_cyc(12);
        repeat (3) pulse_m();
        idle_cyc(3);
        chk(obs === 7'b1000010, "R10 mirror ignored below 16", int'(obs), 7'h42);
        repeat (3) pulse_c();
        wait_vec(7'b0000000, "R10 ends servos off");

        // zero count
        push(7'b1000000, "R11 busy"); push(7'b0000000, "R11 end");
        send(2'd0, 1'b0, 16'd0);
        chk(obs === 7'b1000000, "R11 one busy cycle", int'(obs), 7'h40);
        idle_cyc(1);
        chk(obs === 7'b0000000, "R11 servos unchanged", int'(obs), 7'h00);

        // sled move reverse, 20 tracks: counts mirror edges
        push(7'b1000001, "R10 move rev"); push(7'b0000000, "R10 end rev");
        send(2'd3, 1'b1, 16'd20);
        idle_cyc(12);
        repeat (20) pulse_c();
        idle_cyc(3);
        chk(obs === 7'b1000001, "R10 crossings ignored at 16 and up", int'(obs), 7'h41);
        repeat (20) pulse_m();
        wait_vec(7'b0000000, "R10 ends after mirror edges");

        // single track reverse, tick held low during brake
        push(7'b1000100, "R12 kick rev"); push(7'b1001000, "R12 brake rev");
        push(7'b0110000, "R13 end");
        send(2'd0, 1'b1, 16'd1);
        idle_cyc(12);
        pulse_c();
        wait_vec(7'b1001000, "R12 brake rev start");
        tick = 1'b0;
        repeat (20) @(negedge clk);
        chk(obs === 7'b1001000, "R13 no tick holds brake", int'(obs), 7'h48);
        tick = 1'b1;
        wait_vec(7'b0110000, "R13 ends after tick resumes");

        idle_cyc(4);
        chk(exp_q.size() == 0, "R3 all expected changes seen", exp_q.size(), 0);
        report();
    end

endmodule